// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block is the alarm portion of a real-time clock that is reached through a narrow register port carrying 4-bit data. When the externally selected register bank equals the alarm bank, nine nibble registers hold the alarm digits for seconds, minutes, hours, day of week and day of month. A small control register holds the interrupt enable and the pending flag. Bank selection and the running time counters are supplied from outside, as a bank number and as a vector of current time digits with an update strobe.

On every time update the block compares each alarm field that is not excluded with the matching current digits. A field is excluded by setting the top bit of its tens register, or of the weekday register. When all remaining fields agree, the pending flag is set. It stays set until software writes it back to zero. A level-high interrupt is asserted while the flag is set and the interrupt is enabled.

A typical use is a daily wake-up: software masks the day and weekday fields, loads hh:mm:ss, enables the interrupt, and clears the flag from its handler.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset every alarm digit register reads 0, the control register reads 0 (flag and enable clear), and `irq_o` is low.
- R2: A write with `bank_i` equal to 1 and `reg_addr` in 0x0..0x8 stores `reg_wdata` in that digit register, and it reads back at the same address. A write with any other bank value changes no register.
- R3: The fields are seconds at 0x0 (units) and 0x1 (tens), minutes at 0x2/0x3, hours at 0x4/0x5, day of week at 0x6, and day of month at 0x7/0x8. `now_bcd[4k+3:4k]` carries the current digit for address k. A unit digit is compared on all four bits. A tens digit and the weekday are compared on bits 2:0 only, so bit 3 of those current-time digits is ignored.
- R4: Bit 3 set in a tens register (0x1, 0x3, 0x5, 0x8) or in the weekday register (0x6) removes that field from the comparison. A field removed this way never blocks a match.
- R5: The flag is set on the clock edge where `time_tick` is high and every enabled field equals the current time, and it is visible in the following cycle. A mismatch, or the absence of a tick, leaves it unchanged.
- R6: With all five fields removed, every time update sets the flag.
- R7: With bank 1 selected, address 0xE is the control register: bit 0 is the interrupt enable, bit 1 is the pending flag. A read returns {2'b00, flag, enable}.
- R8: A control write with bit 1 equal to 0 clears the flag. A control write with bit 1 equal to 1 leaves the flag as it was and never sets it. Bit 0 always loads the enable.
- R9: `irq_o` is high exactly while the flag and the enable are both set. It falls in the cycle after the write that clears either one.
- R10: When a matching time update and a flag-clearing control write arrive on the same edge, the flag ends up set.
- R11: Reads return 0 for bank 1 addresses 0x9..0xD and 0xF, and for any other bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_i | input | 2 | Currently selected register bank (alarm bank is 1) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational) |
| time_tick | input | 1 | One-cycle strobe marking a time counter update |
| now_bcd | input | 36 | Current time digits, nibble k for address k |
| irq_o | output | 1 | Level-high alarm interrupt |

## Verification
The bench loads a daily alarm with day and weekday masked. It shows that a time one second early does not match, while the exact hh:mm:ss matches whatever day is presented. A design that compared masked fields would miss that match. It then unmasks the day to show that the day field now blocks a wrong date. It presents a tens digit with bit 3 set, which a full-nibble comparator would reject. It checks that writing the flag bit as 1 neither sets nor clears the flag, which catches a plain register load. It also sends a clearing write on the same edge as a matching tick, where a design with the wrong priority would lose the event. Interrupt gating is exercised by toggling the enable with the flag held. A design that latched the interrupt, or ignored the enable, would keep `irq_o` high after the write.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

  localparam int NUM_FIELDS = 5;
  localparam int NUM_DIGITS = 9;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DAY  = 3'd4
  } field_e;

  // lowest digit address used by a field
  function automatic int field_base(input int f);
    case (f)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 7;
    endcase
  endfunction

  // true when the field has a units and a tens digit
  function automatic bit field_paired(input int f);
    return f != int'(FLD_WDAY);
  endfunction

  // digit carrying the exclude bit of a field
  function automatic int field_mask_digit(input int f);
    return field_paired(f) ? field_base(f) + 1 : field_base(f);
  endfunction

endpackage

// File: rtl/alarm_rst_sync.sv
module alarm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/alarm_digit_regs.sv
module alarm_digit_regs #(
  parameter int DIG_W      = 4,
  parameter int ADDR_W     = 4,
  parameter int NUM_DIGITS = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DIG_W-1:0]                 wr_data,
  output logic [NUM_DIGITS-1:0][DIG_W-1:0] digits
);

  logic [NUM_DIGITS-1:0][DIG_W-1:0] dig_q;
  logic [NUM_DIGITS-1:0][DIG_W-1:0] dig_d;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(k));

    always_comb begin
      dig_d[k] = hit ? wr_data : dig_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dig_q[k] <= '0;
      else        dig_q[k] <= dig_d[k];
    end
  end

  assign digits = dig_q;

endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int DIG_W    = 4,
  parameter int MASK_BIT = 3
) (
  input  logic [NUM_DIGITS-1:0][DIG_W-1:0] alarm_dig,
  input  logic [NUM_DIGITS-1:0][DIG_W-1:0] now_dig,
  output logic                             all_match
);

  localparam int LOW_W = MASK_BIT;

  logic [NUM_FIELDS-1:0] field_ok;
  logic [NUM_FIELDS-1:0] unused_now_msb;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int BASE = field_base(f);
    localparam int MDIG = field_mask_digit(f);
    logic excluded;
    logic equal;

    assign excluded = alarm_dig[MDIG][MASK_BIT];

    if (field_paired(f)) begin : g_pair
      assign equal = (alarm_dig[BASE] == now_dig[BASE]) &&
                     (alarm_dig[BASE+1][LOW_W-1:0] == now_dig[BASE+1][LOW_W-1:0]);
      assign unused_now_msb[f] = ^now_dig[BASE+1][DIG_W-1:LOW_W];
    end else begin : g_single
      assign equal = alarm_dig[BASE][LOW_W-1:0] == now_dig[BASE][LOW_W-1:0];
      assign unused_now_msb[f] = ^now_dig[BASE][DIG_W-1:LOW_W];
    end

    assign field_ok[f] = excluded || equal;
  end

  assign all_match = &field_ok;

endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       time_tick,
  input  logic       all_match,
  input  logic       ctrl_we,
  input  logic [1:0] ctrl_wdata,
  output logic       flag,
  output logic       enable
);

  logic af_q, af_d;
  logic aie_q, aie_d;

  always_comb begin
    aie_d = ctrl_we ? ctrl_wdata[0] : aie_q;
    af_d  = af_q;
    if (ctrl_we && !ctrl_wdata[1]) af_d = 1'b0;
    if (time_tick && all_match)    af_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q  <= 1'b0;
      aie_q <= 1'b0;
    end else begin
      af_q  <= af_d;
      aie_q <= aie_d;
    end
  end

  assign flag   = af_q;
  assign enable = aie_q;

endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_cmp_pkg::*;
#(
  parameter int DIG_W      = 4,
  parameter int ADDR_W     = 4,
  parameter int BANK_W     = 2,
  parameter int ALARM_BANK = 1,
  parameter int CTRL_ADDR  = 14,
  parameter int MASK_BIT   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BANK_W-1:0]           bank_i,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DIG_W-1:0]            reg_wdata,
  output logic [DIG_W-1:0]            reg_rdata,
  input  logic                        time_tick,
  input  logic [NUM_DIGITS*DIG_W-1:0] now_bcd,
  output logic                        irq_o
);

  logic                             rst_sync_n;
  logic                             bank_hit;
  logic                             digit_we;
  logic                             ctrl_we;
  logic                             all_match;
  logic                             af_q;
  logic                             aie_q;
  logic [NUM_DIGITS-1:0][DIG_W-1:0] alarm_dig;
  logic [NUM_DIGITS-1:0][DIG_W-1:0] now_dig;

  assign now_dig  = now_bcd;
  assign bank_hit = bank_i == BANK_W'(ALARM_BANK);
  assign digit_we = reg_we && bank_hit && (reg_addr < ADDR_W'(NUM_DIGITS));
  assign ctrl_we  = reg_we && bank_hit && (reg_addr == ADDR_W'(CTRL_ADDR));

  alarm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  alarm_digit_regs #(
    .DIG_W      (DIG_W),
    .ADDR_W     (ADDR_W),
    .NUM_DIGITS (NUM_DIGITS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (digit_we),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .digits  (alarm_dig)
  );

  alarm_field_cmp #(
    .DIG_W    (DIG_W),
    .MASK_BIT (MASK_BIT)
  ) u_cmp (
    .alarm_dig (alarm_dig),
    .now_dig   (now_dig),
    .all_match (all_match)
  );

  alarm_flag_ctrl u_flag (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .time_tick  (time_tick),
    .all_match  (all_match),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (reg_wdata[1:0]),
    .flag       (af_q),
    .enable     (aie_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (bank_hit) begin
      for (int k = 0; k < NUM_DIGITS; k++) begin
        if (reg_addr == ADDR_W'(k)) reg_rdata = alarm_dig[k];
      end
      if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata = {{(DIG_W-2){1'b0}}, af_q, aie_q};
    end
  end

  assign irq_o = af_q & aie_q;

endmodule

// File: rtl/alarm_match_unit_chk.sv
module alarm_match_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       match,
  input logic       ctrl_we,
  input logic [3:0] wdata,
  input logic       af,
  input logic       aie,
  input logic       irq
);

  // R5
  af_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && match |=> af);

  // R5
  af_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(tick) && $past(match));

  // R8
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !af && !(tick && match) |=> !af);

  // R8
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && !wdata[1] && !(tick && match) |=> !af);

  // R8
  af_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    af && !ctrl_we |=> af);

  // R9
  irq_enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aie |-> !irq);

  // R9
  irq_flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !af |-> !irq);

  // R10
  tick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && tick && match |=> af);

endmodule

bind alarm_match_unit alarm_match_unit_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick    (time_tick),
  .match   (all_match),
  .ctrl_we (ctrl_we),
  .wdata   (reg_wdata),
  .af      (af_q),
  .aie     (aie_q),
  .irq     (irq_o)
);

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;

  logic        clk;
  logic        rst_n;
  logic [1:0]  bank_i;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [3:0]  reg_wdata;
  logic [3:0]  reg_rdata;
  logic        time_tick;
  logic [35:0] now_bcd;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  alarm_match_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_i    (bank_i),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .time_tick (time_tick),
    .now_bcd   (now_bcd),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [35:0] mk_now(input int s, input int m, input int h,
                                         input int wd, input int d);
    logic [35:0] n;
    n[3:0]   = 4'(s % 10);  n[7:4]   = 4'(s / 10);
    n[11:8]  = 4'(m % 10);  n[15:12] = 4'(m / 10);
    n[19:16] = 4'(h % 10);  n[23:20] = 4'(h / 10);
    n[27:24] = 4'(wd);
    n[31:28] = 4'(d % 10);  n[35:32] = 4'(d / 10);
    return n;
  endfunction

  task automatic wr(input logic [1:0] b, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    bank_i = b; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] b, input logic [3:0] a, output int v);
    bank_i = b; reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic tick(input logic [35:0] n);
    @(negedge clk);
    now_bcd = n; time_tick = 1'b1;
    @(negedge clk);
    time_tick = 1'b0;
  endtask

  // mask bits: [0] sec, [1] min, [2] hour, [3] weekday, [4] day
  task automatic prog_alarm(input int s, input int m, input int h, input int wd,
                            input int d, input logic [4:0] msk);
    logic [35:0] n;
    n = mk_now(s, m, h, wd, d);
    for (int k = 0; k < 9; k++) wr(2'd1, 4'(k), n[4*k +: 4]);
    if (msk[0]) wr(2'd1, 4'h1, n[7:4]   | 4'h8);
    if (msk[1]) wr(2'd1, 4'h3, n[15:12] | 4'h8);
    if (msk[2]) wr(2'd1, 4'h5, n[23:20] | 4'h8);
    if (msk[3]) wr(2'd1, 4'h6, n[27:24] | 4'h8);
    if (msk[4]) wr(2'd1, 4'h8, n[35:32] | 4'h8);
  endtask

  task automatic t_reset;
    int v;
    for (int k = 0; k < 9; k++) begin
      rd(2'd1, 4'(k), v);
      check("R1 digit reset", v, 0);
    end
    rd(2'd1, 4'hE, v);
    check("R1 control reset", v, 0);
    check("R1 irq reset", int'(irq_o), 0);
  endtask

  task automatic t_regs;
    int v;
    wr(2'd1, 4'h2, 4'h7);
    rd(2'd1, 4'h2, v);
    check("R2 readback", v, 7);
    wr(2'd0, 4'h2, 4'h3);
    rd(2'd1, 4'h2, v);
    check("R2 other bank write ignored", v, 7);
    wr(2'd2, 4'hE, 4'h3);
    rd(2'd1, 4'hE, v);
    check("R2 other bank ctrl write ignored", v, 0);
    rd(2'd0, 4'h2, v);
    check("R11 other bank reads zero", v, 0);
    rd(2'd1, 4'hA, v);
    check("R11 unused address reads zero", v, 0);
    rd(2'd1, 4'hF, v);
    check("R11 address F reads zero", v, 0);
  endtask

  task automatic t_daily;
    int v;
    prog_alarm(56, 34, 12, 0, 0, 5'b11000);
    rd(2'd1, 4'h8, v);
    check("R4 day tens holds exclude bit", v, 8);
    tick(mk_now(55, 34, 12, 2, 9));
    rd(2'd1, 4'hE, v);
    check("R5 early second no match", v, 0);
    tick(mk_now(56, 34, 12, 3, 17));
    rd(2'd1, 4'hE, v);
    check("R5 R4 match with day masked sets flag", v, 2);
    check("R9 irq low with enable clear", int'(irq_o), 0);
  endtask

  task automatic t_irq;
    int v;
    wr(2'd1, 4'hE, 4'h3);
    rd(2'd1, 4'hE, v);
    check("R8 write flag as 1 keeps flag", v, 3);
    check("R9 irq high", int'(irq_o), 1);
    wr(2'd1, 4'hE, 4'h2);
    check("R9 irq falls when enable cleared", int'(irq_o), 0);
    rd(2'd1, 4'hE, v);
    check("R7 control layout", v, 2);
    wr(2'd1, 4'hE, 4'h3);
    check("R9 irq back", int'(irq_o), 1);
    wr(2'd1, 4'hE, 4'h1);
    check("R9 irq falls when flag cleared", int'(irq_o), 0);
    rd(2'd1, 4'hE, v);
    check("R8 flag cleared by write of 0", v, 1);
    wr(2'd1, 4'hE, 4'h3);
    rd(2'd1, 4'hE, v);
    check("R8 write 1 does not set flag", v, 1);
    check("R9 irq stays low", int'(irq_o), 0);
    wr(2'd1, 4'hE, 4'h0);
  endtask

  task automatic t_day_field;
    int v;
    logic [35:0] n;
    wr(2'd1, 4'h8, 4'h2);
    wr(2'd1, 4'h7, 4'h7);
    tick(mk_now(56, 34, 12, 4, 17));
    rd(2'd1, 4'hE, v);
    check("R3 enabled day mismatch blocks", v, 0);
    tick(mk_now(56, 34, 12, 4, 27));
    rd(2'd1, 4'hE, v);
    check("R3 day match sets flag", v, 2);
    wr(2'd1, 4'hE, 4'h0);
    n = mk_now(56, 34, 12, 4, 27);
    n[7:4] = 4'hD;
    tick(n);
    rd(2'd1, 4'hE, v);
    check("R3 tens bit 3 of time ignored", v, 2);
    wr(2'd1, 4'hE, 4'h0);
    n = mk_now(56, 34, 12, 4, 27);
    n[27:24] = 4'h5;
    tick(n);
    rd(2'd1, 4'hE, v);
    check("R4 weekday masked ignores weekday", v, 2);
    wr(2'd1, 4'hE, 4'h0);
    wr(2'd1, 4'h3, 4'hB);
    tick(mk_now(56, 0, 12, 4, 27));
    rd(2'd1, 4'hE, v);
    check("R4 masked minutes ignored", v, 2);
    wr(2'd1, 4'hE, 4'h0);
  endtask

  task automatic t_all_masked;
    int v;
    prog_alarm(1, 2, 3, 4, 5, 5'b11111);
    tick(mk_now(42, 17, 9, 1, 30));
    rd(2'd1, 4'hE, v);
    check("R6 all masked first tick", v, 2);
    wr(2'd1, 4'hE, 4'h0);
    tick(mk_now(7, 59, 23, 6, 1));
    rd(2'd1, 4'hE, v);
    check("R6 all masked second tick", v, 2);
    @(negedge clk);
    bank_i = 2'd1; reg_addr = 4'hE; reg_wdata = 4'h0; reg_we = 1'b1;
    now_bcd = mk_now(8, 0, 0, 0, 2); time_tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; time_tick = 1'b0;
    rd(2'd1, 4'hE, v);
    check("R10 tick wins over clear", v, 2);
    wr(2'd1, 4'hE, 4'h0);
    @(negedge clk);
    rd(2'd1, 4'hE, v);
    check("R5 no tick no set", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; bank_i = 2'd0; reg_we = 1'b0; reg_addr = '0;
    reg_wdata = '0; time_tick = 1'b0; now_bcd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_daily;
    t_irq;
    t_day_field;
    t_all_masked;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule